// File: doc/BRIEF.md
# Software Interrupt Delivery Gate

This block keeps the state a core needs to decide whether a software-raised interrupt may be taken. It holds a pending-request register, a four-bit priority floor, and local copies of the processor control word and the hypervisor control word. All of these are loaded through a single register-write port. From that state the block works out the highest pending level. It raises an interrupt request toward the core when that level may be taken.

Pending bits build up: a set write adds bits and a clear write removes them, so software can queue several levels and retire them one at a time. The block also produces a one-cycle recheck strobe. It fires on exactly those register updates that can turn a blocked interrupt into a deliverable one, so the core's trap logic only needs to look again when the strobe fires. The write port has no ready signal and cannot apply back-pressure. A write presented with `wr_en` high is taken on that clock edge.

Top module: `sip_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 ORs `wr_data` into the pending register. Bits that are already set stay set.
- R2: A write with `wr_sel`=1 clears every pending bit that is 1 in `wr_data` and leaves the other bits alone. `irq_req` drops in the cycle after the write that clears the bit deciding the level.
- R3: The pending level is the index of the highest set bit among bits 1 to PEND_W-1. Bit 0 never produces a level, and a level of 0 means nothing is pending.
- R4: A request is delivered only if its level is strictly greater than the priority floor. The floor is loaded from `wr_data[LVL_W-1:0]` by a write with `wr_sel`=2. At a level equal to or below the floor, `irq_req` stays low.
- R5: While bit 1 (enable) of the processor control word is 0, `irq_req` stays low. The processor control word is loaded by a write with `wr_sel`=3.
- R6: While bit 2 (hypervisor privilege) of the hypervisor control word is 1, `irq_req` stays low, whatever the floor and enable values are. The hypervisor control word is loaded by a write with `wr_sel`=4.
- R7: A write to the hypervisor control word stores `wr_data` with bit 11 forced to 1.
- R8: Every write with `wr_sel`=0 pulses `recheck`, including a write of zero.
- R9: A processor-control write pulses `recheck` only when it moves the enable bit from 0 to 1.
- R10: A floor write pulses `recheck` only when the new floor is smaller than the current one.
- R11: After reset the pending register is 0, the floor is all ones (15), the processor control word is 0, and the hypervisor control word is 0x800. `irq_req`, `irq_lvl` and `recheck` are all 0.
- R12: Clear writes, hypervisor-control writes and writes with `wr_sel` codes 5 to 7 never pulse `recheck`. Codes 5 to 7 change no state.
- R13: A write becomes visible on the outputs in the cycle after the clock edge that takes it. `recheck` is high for that one cycle only. `irq_lvl` is 0 whenever `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 set, 1 clear, 2 floor, 3 processor control, 4 hypervisor control |
| wr_data | input | DATA_W | Write value |
| irq_req | output | 1 | Interrupt request to the core |
| irq_lvl | output | LVL_W | Level of the request; 0 when no request |
| recheck | output | 1 | One-cycle strobe asking the core to re-evaluate interrupts |
| proc_state | output | CTL_W | Current processor control word |
| hv_state | output | CTL_W | Current hypervisor control word |

## Verification
The bench builds the block with DATA_W=16, PEND_W=16 and CTL_W=12. With these values the full level range from 1 to 15 is in reach, and so is the reset floor of 15, under which nothing can be delivered until the floor is lowered. Bit 11 of the hypervisor word, the bit that is forced high, also falls inside the stored width. A reference model in the bench, driven by the same writes, predicts request, level, strobe and both control words for every cycle. Among the cases it covers are a floor equal to the level, a floor being raised, an enable bit that was already set, a pending bit 0 on its own, and the hypervisor override overruling a floor of zero.

// File: rtl/sip_pkg.sv
`timescale 1ns/1ps
package sip_pkg;
  typedef enum logic [2:0] {
    SEL_PEND_SET = 3'd0,
    SEL_PEND_CLR = 3'd1,
    SEL_FLOOR    = 3'd2,
    SEL_PROC     = 3'd3,
    SEL_HV       = 3'd4
  } sip_sel_e;

  localparam int IE_BIT       = 1;
  localparam int HV_PRIV_BIT  = 2;
  localparam int HV_FIXED_BIT = 11;
endpackage

// File: rtl/sip_pend_reg.sv
`timescale 1ns/1ps
module sip_pend_reg #(
  parameter int PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [PEND_W-1:0] mask,
  output logic [PEND_W-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (set_en) begin
      pend_q <= pend_q | mask;   // accumulate
    end else if (clr_en) begin
      pend_q <= pend_q & ~mask;  // write-one-to-clear
    end
  end
endmodule

// File: rtl/sip_prio_enc.sv
`timescale 1ns/1ps
module sip_prio_enc #(
  parameter int PEND_W = 16,
  parameter int LVL_W  = $clog2(PEND_W)
) (
  input  logic [PEND_W-1:0] pend,
  output logic [LVL_W-1:0]  lvl
);
  logic unused_bit0;
  assign unused_bit0 = pend[0];

  // highest set bit wins; bit 0 carries no level
  always_comb begin
    lvl = '0;
    for (int i = 1; i < PEND_W; i++) begin
      if (pend[i]) lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/sip_ctl_regs.sv
`timescale 1ns/1ps
module sip_ctl_regs #(
  parameter int CTL_W = 12,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             floor_stb,
  input  logic             proc_stb,
  input  logic             hv_stb,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic [LVL_W-1:0] floor_data,
  output logic [LVL_W-1:0] floor_q,
  output logic [CTL_W-1:0] proc_q,
  output logic [CTL_W-1:0] hv_q,
  output logic             recheck_q
);
  import sip_pkg::*;

  localparam logic [CTL_W-1:0] HV_FORCE = CTL_W'(1) << HV_FIXED_BIT;

  logic enable_rise;
  logic floor_drop;
  assign enable_rise = proc_stb & ctl_data[IE_BIT] & ~proc_q[IE_BIT];
  assign floor_drop  = floor_stb & (floor_data < floor_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q   <= '1;
      proc_q    <= '0;
      hv_q      <= HV_FORCE;
      recheck_q <= 1'b0;
    end else begin
      recheck_q <= set_stb | enable_rise | floor_drop;
      if (floor_stb) floor_q <= floor_data;
      if (proc_stb)  proc_q  <= ctl_data;
      if (hv_stb)    hv_q    <= ctl_data | HV_FORCE;
    end
  end
endmodule

// File: rtl/sip_gate.sv
`timescale 1ns/1ps
module sip_gate #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] floor_lvl,
  input  logic             enable,
  input  logic             hv_priv,
  output logic             req,
  output logic [LVL_W-1:0] req_lvl
);
  always_comb begin
    req     = (lvl != '0) && (lvl > floor_lvl) && enable && !hv_priv;
    req_lvl = req ? lvl : '0;
  end
endmodule

// File: rtl/sip_ctrl.sv
`timescale 1ns/1ps
module sip_ctrl #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 16,
  parameter int CTL_W  = 12,
  parameter int LVL_W  = $clog2(PEND_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_lvl,
  output logic              recheck,
  output logic [CTL_W-1:0]  proc_state,
  output logic [CTL_W-1:0]  hv_state
);
  import sip_pkg::*;

  sip_sel_e sel;
  logic set_stb, clr_stb, floor_stb, proc_stb, hv_stb;
  logic [PEND_W-1:0] pend_q;
  logic [LVL_W-1:0]  floor_q;
  logic [LVL_W-1:0]  top_lvl;

  assign sel       = sip_sel_e'(wr_sel);
  assign set_stb   = wr_en && (sel == SEL_PEND_SET);
  assign clr_stb   = wr_en && (sel == SEL_PEND_CLR);
  assign floor_stb = wr_en && (sel == SEL_FLOOR);
  assign proc_stb  = wr_en && (sel == SEL_PROC);
  assign hv_stb    = wr_en && (sel == SEL_HV);

  sip_pend_reg #(.PEND_W(PEND_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_stb),
    .clr_en (clr_stb),
    .mask   (wr_data[PEND_W-1:0]),
    .pend_q (pend_q)
  );

  sip_prio_enc #(.PEND_W(PEND_W), .LVL_W(LVL_W)) u_enc (
    .pend (pend_q),
    .lvl  (top_lvl)
  );

  sip_ctl_regs #(.CTL_W(CTL_W), .LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_stb    (set_stb),
    .floor_stb  (floor_stb),
    .proc_stb   (proc_stb),
    .hv_stb     (hv_stb),
    .ctl_data   (wr_data[CTL_W-1:0]),
    .floor_data (wr_data[LVL_W-1:0]),
    .floor_q    (floor_q),
    .proc_q     (proc_state),
    .hv_q       (hv_state),
    .recheck_q  (recheck)
  );

  sip_gate #(.LVL_W(LVL_W)) u_gate (
    .lvl       (top_lvl),
    .floor_lvl (floor_q),
    .enable    (proc_state[IE_BIT]),
    .hv_priv   (hv_state[HV_PRIV_BIT]),
    .req       (irq_req),
    .req_lvl   (irq_lvl)
  );
endmodule

// File: rtl/sip_chk.sv
`timescale 1ns/1ps
module sip_chk #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 16,
  parameter int CTL_W  = 12,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_req,
  input logic [LVL_W-1:0]  irq_lvl,
  input logic              recheck,
  input logic [CTL_W-1:0]  proc_state,
  input logic [CTL_W-1:0]  hv_state,
  input logic [LVL_W-1:0]  floor_q,
  input logic [PEND_W-1:0] pend_q
);
  p_accumulate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=>
      ((pend_q & $past(wr_data[PEND_W-1:0])) == $past(wr_data[PEND_W-1:0])) &&
      ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> ((pend_q & $past(wr_data[PEND_W-1:0])) == '0));

  p_above_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > floor_q));

  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> proc_state[1]);

  p_hv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hv_state[2] |-> !irq_req);

  p_hv_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hv_state[11]);

  p_set_recheck_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> recheck);

  p_recheck_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    recheck |-> ($past(wr_en) && ($past(wr_sel) inside {3'd0, 3'd2, 3'd3})));

  p_lvl_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_lvl == '0));
endmodule

bind sip_ctrl sip_chk #(
  .DATA_W(DATA_W), .PEND_W(PEND_W), .CTL_W(CTL_W), .LVL_W(LVL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .irq_req    (irq_req),
  .irq_lvl    (irq_lvl),
  .recheck    (recheck),
  .proc_state (proc_state),
  .hv_state   (hv_state),
  .floor_q    (floor_q),
  .pend_q     (pend_q)
);

// File: tb/sip_ctrl_bench.sv
`timescale 1ns/1ps
module sip_ctrl_bench;
  localparam int DATA_W = 16;
  localparam int PEND_W = 16;
  localparam int CTL_W  = 12;
  localparam int LVL_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              irq_req;
  logic [LVL_W-1:0]  irq_lvl;
  logic              recheck;
  logic [CTL_W-1:0]  proc_state;
  logic [CTL_W-1:0]  hv_state;

  always #4 clk = ~clk;  // 125 MHz

  sip_ctrl #(.DATA_W(DATA_W), .PEND_W(PEND_W), .CTL_W(CTL_W)) u_sip_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .recheck(recheck),
    .proc_state(proc_state), .hv_state(hv_state)
  );

  typedef struct packed {
    logic             req;
    logic [LVL_W-1:0] lvl;
    logic             rck;
    logic [CTL_W-1:0] proc;
    logic [CTL_W-1:0] hv;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  // reference model state, from the requirements
  logic [PEND_W-1:0] m_pend  = '0;
  logic [LVL_W-1:0]  m_floor = '1;
  logic [CTL_W-1:0]  m_proc  = '0;
  logic [CTL_W-1:0]  m_hv    = CTL_W'(12'h800);

  function automatic exp_t predict(input logic rck);
    exp_t e;
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = 1; i < PEND_W; i++) if (m_pend[i]) l = LVL_W'(i);
    e.req  = (l != '0) && (l > m_floor) && m_proc[1] && !m_hv[2];
    e.lvl  = e.req ? l : '0;
    e.rck  = rck;
    e.proc = m_proc;
    e.hv   = m_hv;
    return e;
  endfunction

  task automatic drive(input logic [2:0] sel, input logic [DATA_W-1:0] d, input string tag);
    logic rck;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    rck = 1'b0;
    case (sel)
      3'd0: begin m_pend = m_pend | d; rck = 1'b1; end
      3'd1: m_pend = m_pend & ~d;
      3'd2: begin rck = (d[LVL_W-1:0] < m_floor); m_floor = d[LVL_W-1:0]; end
      3'd3: begin rck = d[1] && !m_proc[1]; m_proc = d[CTL_W-1:0]; end
      3'd4: m_hv = d[CTL_W-1:0] | CTL_W'(12'h800);
      default: ;
    endcase
    @(posedge clk);
    exp_q.push_back(predict(rck));
    tag_q.push_back(tag);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    @(posedge clk);
    exp_q.push_back(predict(1'b0));
    tag_q.push_back(tag);
    #1;
  endtask

  // monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.req = irq_req; a.lvl = irq_lvl; a.rck = recheck;
      a.proc = proc_state; a.hv = hv_state;
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s: req=%0b lvl=%0d rck=%0b proc=%h hv=%h expected req=%0b lvl=%0d rck=%0b proc=%h hv=%h",
                 t, a.req, a.lvl, a.rck, a.proc, a.hv, e.req, e.lvl, e.rck, e.proc, e.hv);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R11 reset state");
    drive(3'd0, 16'h0020, "R1 R8 set bit5, blocked by floor and enable");
    idle("R13 recheck is single cycle");
    drive(3'd3, 16'h0002, "R9 enable rise, R4 floor 15 still blocks");
    drive(3'd3, 16'h0002, "R9 enable already set, no strobe");
    drive(3'd2, 16'h0005, "R10 floor drop, R4 level equal to floor blocks");
    drive(3'd2, 16'h0005, "R10 equal floor, no strobe");
    drive(3'd2, 16'h0004, "R4 level above floor delivered");
    drive(3'd0, 16'h0100, "R1 R3 accumulate bit8, level 8");
    drive(3'd1, 16'h0100, "R2 R12 clear bit8, back to level 5");
    drive(3'd0, 16'h0001, "R3 bit0 adds no level");
    drive(3'd1, 16'h0020, "R2 R3 only bit0 left, no request");
    drive(3'd0, 16'h0000, "R8 zero set write still strobes");
    drive(3'd0, 16'h8000, "R3 top level 15");
    drive(3'd4, 16'h0004, "R6 R7 R12 hypervisor privilege holds request");
    drive(3'd2, 16'h0000, "R6 floor zero still held");
    drive(3'd4, 16'h0000, "R7 bit11 forced, request released");
    drive(3'd3, 16'h0000, "R5 R9 enable cleared blocks, no strobe");
    drive(3'd2, 16'h000E, "R10 floor raised, no strobe");
    drive(3'd3, 16'h03F2, "R9 R5 enable rise with other fields, delivered");
    drive(3'd5, 16'hFFFF, "R12 unused code changes nothing");
    drive(3'd7, 16'h0000, "R12 unused code changes nothing");
    drive(3'd1, 16'hFFFF, "R2 clear all drops request next cycle");
    idle("R13 quiet after clear");
    @(negedge clk);
    #1;
    done = 1'b1;
    report();
  end
endmodule